// File: doc/BRIEF.md
# Power Key On/Off Sequencer

This block sequences the power state of a cellular modem from two active-low push inputs: a power key and an emergency-off line. A millisecond tick enable paces every delay. A press of the power key held long enough while the modem is down starts a staged power-up. The external supply enable rises first. The STATUS output follows once boot is deemed complete. In the running state, a second qualified press or a latched supply fault starts an orderly shutdown. That shutdown finishes after a fixed acknowledge delay, which stands in for a software handshake.

A qualified emergency-off press cuts power at once from any powered state. After any power-down, a lockout window must expire before a new power-on press can begin to qualify. The window after an emergency cut is longer than the window after a normal turn-off. All three asynchronous inputs pass through two-flop synchronisers. Every delay is a parameter counted in ticks.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset, `supply_en` and `status_o` are low, the block is powered down, and no lockout is pending.
- R2: While powered down, `pwrkey_n` must be held low for more than ON_HOLD_MS ticks (qualification completes on tick ON_HOLD_MS+1) to start power-up. A shorter press has no effect on either output.
- R3: `supply_en` rises SUPPLY_DLY_MS ticks after the power-on press qualifies.
- R4: `status_o` rises STATUS_DLY_MS ticks after `supply_en` rises, which marks the running state. `status_o` is never high while `supply_en` is low.
- R5: While running, a power key press held for OFF_HOLD_MS ticks starts shutdown. Hold time is counted only while in the running state. After ACK_DLY_MS further ticks, `supply_en` and `status_o` fall in the same cycle.
- R6: `emrg_off_n` held low for EMRG_HOLD_MS ticks in any powered state drives both outputs low in the cycle after qualification. A shorter low pulse has no effect.
- R7: After a normal turn-off, power key hold time starts counting only once LOCK_NORM_MS ticks have elapsed since the outputs fell.
- R8: After an emergency cut, power key hold time starts counting only once LOCK_EMRG_MS ticks have elapsed.
- R9: A high level on `supply_fault` while powered is latched. When the block is running, or on reaching the running state, the latch starts the same orderly shutdown as R5. The latch clears when the block powers down. A fault seen while powered down is ignored.
- R10: Timers advance only in cycles with `tick_ms` high. Neither output changes in the cycle after a cycle with `tick_ms` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle enable per millisecond |
| pwrkey_n | input | 1 | Power key, active low, asynchronous |
| emrg_off_n | input | 1 | Emergency-off line, active low, asynchronous |
| supply_fault | input | 1 | Supply fault indication, active high, asynchronous |
| supply_en | output | 1 | External supply enable |
| status_o | output | 1 | High while running or shutting down |

## Verification
A wrong internal state shows up on the two outputs within one tick of the transition that should have occurred. A timer that ends a phase early or late moves the edge of `supply_en` or `status_o` by the same number of ticks. A lockout or hold counter that is skipped or never cleared moves the power-up edge by hundreds of ticks, or removes it. A fault latch that leaks into the powered-down state drops `status_o` one acknowledge delay after it first rises.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

    typedef enum logic [2:0] {
        PS_OFF     = 3'd0,
        PS_POWERUP = 3'd1,
        PS_BOOT    = 3'd2,
        PS_RUN     = 3'd3,
        PS_SHUT    = 3'd4
    } pseq_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int cbits(input int v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/pseq_sync.sv
module pseq_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= RST_VAL;
            end else if (s == 0) begin
                stage_q[s] <= async_i;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/pseq_hold_qual.sv
// Counts enabled ticks while an active-low input stays low; emits a single
// pulse on the tick that brings the count to LIMIT, then saturates until the
// input is released or the enable drops.
module pseq_hold_qual #(
    parameter int LIMIT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic held,
    output logic fire
);

    localparam int CW = pseq_pkg::cbits(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
    localparam logic [CW-1:0] FULL = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        fire  = 1'b0;
        if (!en || !held) begin
            cnt_d = '0;
        end else if (tick && (cnt_q != FULL)) begin
            cnt_d = cnt_q + 1'b1;
            fire  = (cnt_q == LAST);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
    parameter int ON_HOLD_MS    = 1000,
    parameter int SUPPLY_DLY_MS = 54,
    parameter int STATUS_DLY_MS = 800,
    parameter int OFF_HOLD_MS   = 1000,
    parameter int ACK_DLY_MS    = 100,
    parameter int EMRG_HOLD_MS  = 20,
    parameter int LOCK_NORM_MS  = 500,
    parameter int LOCK_EMRG_MS  = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ms,
    input  logic pwrkey_n,
    input  logic emrg_off_n,
    input  logic supply_fault,
    output logic supply_en,
    output logic status_o
);
    import pseq_pkg::*;

    localparam int TW = cbits(max2(max2(SUPPLY_DLY_MS, STATUS_DLY_MS), ACK_DLY_MS));
    localparam int LW = cbits(max2(LOCK_NORM_MS, LOCK_EMRG_MS));
    localparam logic [TW-1:0] SUP_END  = TW'(SUPPLY_DLY_MS - 1);
    localparam logic [TW-1:0] BOOT_END = TW'(STATUS_DLY_MS - 1);
    localparam logic [TW-1:0] ACK_END  = TW'(ACK_DLY_MS - 1);
    localparam logic [LW-1:0] LOCK_N   = LW'(LOCK_NORM_MS);
    localparam logic [LW-1:0] LOCK_E   = LW'(LOCK_EMRG_MS);

    typedef struct packed {
        pseq_state_e   st;
        logic [TW-1:0] tmr;
        logic [LW-1:0] lock;
        logic          fault;
        logic          sup;
        logic          stat;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    // synchronised inputs: bit0 key, bit1 emergency, bit2 fault
    logic [2:0] in_s;
    logic       key_low_s, emrg_low_s, fault_s;
    logic       lock_busy, on_en, off_en;
    logic       on_fire, off_fire, emrg_fire;

    pseq_sync #(.W(3), .STAGES(2), .RST_VAL(3'b011)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({supply_fault, emrg_off_n, pwrkey_n}),
        .sync_o  (in_s)
    );

    assign key_low_s  = ~in_s[0];
    assign emrg_low_s = ~in_s[1];
    assign fault_s    = in_s[2];

    assign lock_busy = (r_q.lock != '0);
    assign on_en     = (r_q.st == PS_OFF) && !lock_busy;
    assign off_en    = (r_q.st == PS_RUN);

    pseq_hold_qual #(.LIMIT(ON_HOLD_MS + 1)) u_on_qual (
        .clk(clk), .rst_n(rst_n), .en(on_en), .tick(tick_ms),
        .held(key_low_s), .fire(on_fire)
    );

    pseq_hold_qual #(.LIMIT(OFF_HOLD_MS)) u_off_qual (
        .clk(clk), .rst_n(rst_n), .en(off_en), .tick(tick_ms),
        .held(key_low_s), .fire(off_fire)
    );

    pseq_hold_qual #(.LIMIT(EMRG_HOLD_MS)) u_emrg_qual (
        .clk(clk), .rst_n(rst_n), .en(1'b1), .tick(tick_ms),
        .held(emrg_low_s), .fire(emrg_fire)
    );

    always_comb begin
        r_d = r_q;
        if ((r_q.st != PS_OFF) && fault_s) r_d.fault = 1'b1;

        unique case (r_q.st)
            PS_OFF: begin
                r_d.sup   = 1'b0;
                r_d.stat  = 1'b0;
                r_d.fault = 1'b0;
                if (tick_ms && lock_busy) r_d.lock = r_q.lock - 1'b1;
                if (on_fire) begin
                    r_d.st  = PS_POWERUP;
                    r_d.tmr = '0;
                end
            end
            PS_POWERUP: begin
                if (tick_ms) begin
                    if (r_q.tmr == SUP_END) begin
                        r_d.st  = PS_BOOT;
                        r_d.tmr = '0;
                        r_d.sup = 1'b1;
                    end else begin
                        r_d.tmr = r_q.tmr + 1'b1;
                    end
                end
            end
            PS_BOOT: begin
                if (tick_ms) begin
                    if (r_q.tmr == BOOT_END) begin
                        r_d.st   = PS_RUN;
                        r_d.tmr  = '0;
                        r_d.stat = 1'b1;
                    end else begin
                        r_d.tmr = r_q.tmr + 1'b1;
                    end
                end
            end
            PS_RUN: begin
                if (off_fire || r_q.fault) begin
                    r_d.st  = PS_SHUT;
                    r_d.tmr = '0;
                end
            end
            PS_SHUT: begin
                if (tick_ms) begin
                    if (r_q.tmr == ACK_END) begin
                        r_d.st    = PS_OFF;
                        r_d.tmr   = '0;
                        r_d.sup   = 1'b0;
                        r_d.stat  = 1'b0;
                        r_d.fault = 1'b0;
                        r_d.lock  = LOCK_N;
                    end else begin
                        r_d.tmr = r_q.tmr + 1'b1;
                    end
                end
            end
            default: begin
                r_d.st = PS_OFF;
            end
        endcase

        // emergency cut overrides every powered state
        if (emrg_fire && (r_q.st != PS_OFF)) begin
            r_d.st    = PS_OFF;
            r_d.tmr   = '0;
            r_d.sup   = 1'b0;
            r_d.stat  = 1'b0;
            r_d.fault = 1'b0;
            r_d.lock  = LOCK_E;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= PS_OFF;
            r_q.tmr   <= '0;
            r_q.lock  <= '0;
            r_q.fault <= 1'b0;
            r_q.sup   <= 1'b0;
            r_q.stat  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign supply_en = r_q.sup;
    assign status_o  = r_q.stat;

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick_ms,
    input logic                 supply_en,
    input logic                 status_o,
    input logic                 emrg_fire,
    input logic                 lock_busy,
    input pseq_pkg::pseq_state_e st
);
    import pseq_pkg::*;

    a_r4_status_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
        status_o |-> supply_en);

    a_r5_drop_together: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o) |-> $fell(supply_en));

    a_r6_emrg_cuts: assert property (@(posedge clk) disable iff (!rst_n)
        (emrg_fire && (st != PS_OFF)) |=> (!supply_en && !status_o));

    a_r7_lock_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == PS_OFF) && lock_busy) |=> (st == PS_OFF));

    a_r10_no_tick_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_ms |=> ($stable(supply_en) && $stable(status_o)));

endmodule

bind pwr_seq_ctrl pwr_seq_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_ms   (tick_ms),
    .supply_en (supply_en),
    .status_o  (status_o),
    .emrg_fire (emrg_fire),
    .lock_busy (lock_busy),
    .st        (r_q.st)
);

// File: tb/pwr_seq_ctrl_tb_top.sv
module pwr_seq_ctrl_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_ms = 1'b1;
    logic pwrkey_n = 1'b1;
    logic emrg_off_n = 1'b1;
    logic supply_fault = 1'b0;
    logic supply_en, status_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwr_seq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .pwrkey_n(pwrkey_n),
        .emrg_off_n(emrg_off_n), .supply_fault(supply_fault),
        .supply_en(supply_en), .status_o(status_o)
    );

    task automatic chk(input logic act, input logic exp, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Timings below count negedges from the negedge that drives the input.
    // Power-on: qualification after 2 sync stages + 1001 ticks, supply 54 later.
    task automatic t_reset;
        chk(supply_en, 1'b0, "R1 supply after reset");
        chk(status_o, 1'b0, "R1 status after reset");
    endtask

    task automatic t_short_press;
        pwrkey_n = 1'b0; wait_n(900); pwrkey_n = 1'b1; wait_n(200);
        chk(supply_en, 1'b0, "R2 short press ignored");
        tick_ms = 1'b0; pwrkey_n = 1'b0; wait_n(1500);
        chk(supply_en, 1'b0, "R10 no ticks no power-on");
        pwrkey_n = 1'b1; wait_n(5); tick_ms = 1'b1; wait_n(5);
        chk(supply_en, 1'b0, "R10 still off after release");
    endtask

    task automatic t_power_on;
        pwrkey_n = 1'b0;
        wait_n(1048); chk(supply_en, 1'b0, "R3 supply not yet");
        wait_n(16);   chk(supply_en, 1'b1, "R3 supply up");
        wait_n(6);    pwrkey_n = 1'b1;
        wait_n(778);  chk(status_o, 1'b0, "R4 status not yet");
        wait_n(16);   chk(status_o, 1'b1, "R4 status up");
    endtask

    task automatic t_power_off_lock;
        pwrkey_n = 1'b0;
        wait_n(1094); chk(status_o, 1'b1, "R5 status held during ack");
        chk(supply_en, 1'b1, "R5 supply held during ack");
        wait_n(16);   chk(status_o, 1'b0, "R5 status dropped");
        chk(supply_en, 1'b0, "R5 supply dropped");
        // key still held: counting resumes only after the normal lockout
        wait_n(1530); chk(supply_en, 1'b0, "R7 lockout delays power-on");
        wait_n(32);   chk(supply_en, 1'b1, "R7 power-on after lockout");
        pwrkey_n = 1'b1;
        wait_n(820);  chk(status_o, 1'b1, "R4 running again");
    endtask

    task automatic t_emergency;
        emrg_off_n = 1'b0; wait_n(15); emrg_off_n = 1'b1; wait_n(30);
        chk(supply_en, 1'b1, "R6 short emergency ignored");
        emrg_off_n = 1'b0;
        wait_n(10); chk(status_o, 1'b1, "R6 before emergency hold");
        wait_n(20); chk(supply_en, 1'b0, "R6 emergency cut supply");
        chk(status_o, 1'b0, "R6 emergency cut status");
        emrg_off_n = 1'b1; wait_n(10);
        pwrkey_n = 1'b0;
        wait_n(3020); chk(supply_en, 1'b0, "R8 long lockout delays power-on");
        wait_n(30);   chk(supply_en, 1'b1, "R8 power-on after long lockout");
        pwrkey_n = 1'b1;
        wait_n(820);  chk(status_o, 1'b1, "R8 running after restart");
    endtask

    task automatic t_fault;
        supply_fault = 1'b1; wait_n(3); supply_fault = 1'b0;
        wait_n(50);  chk(status_o, 1'b1, "R9 ack window after fault");
        wait_n(70);  chk(status_o, 1'b0, "R9 fault shutdown");
        chk(supply_en, 1'b0, "R9 fault drops supply");
        wait_n(600);
        pwrkey_n = 1'b0; wait_n(1070); pwrkey_n = 1'b1;
        wait_n(230); supply_fault = 1'b1; wait_n(3); supply_fault = 1'b0;
        wait_n(567); chk(status_o, 1'b1, "R9 latched fault reaches running");
        wait_n(100); chk(status_o, 1'b0, "R9 latched fault shuts down");
        wait_n(600);
        supply_fault = 1'b1; wait_n(5); supply_fault = 1'b0; wait_n(5);
        pwrkey_n = 1'b0; wait_n(1070); pwrkey_n = 1'b1;
        wait_n(800); chk(status_o, 1'b1, "R9 fault while off ignored, up");
        wait_n(230); chk(status_o, 1'b1, "R9 fault while off ignored, stays");
    endtask

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(3);
        t_reset();
        t_short_press();
        t_power_on();
        t_power_off_lock();
        t_emergency();
        t_fault();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule